// File: doc/BRIEF.md
# Wave32 Condition-Mask Branch Unit

This block sits beside a scalar sequencer. It holds a 64-bit vector condition register and a 64-bit lane-enable mask. Each register is stored as two 32-bit halves, and each half can be written on its own from a shared write-data bus. The block also resolves conditional branches that ask whether the condition register is zero or nonzero, and it produces the next program counter.

A mode input selects 32-lane or 64-lane operation. In 32-lane mode the high halves of both registers are still kept, but they are hidden. The branch test and the register views given to the rest of the pipe see only the low 32 bits. Stale bits left in a high half therefore can never steer a branch. In 64-lane mode the full width is used.

The program counter is handled as a dword index, and its byte address is also given. A branch request carries a kind code, a signed 16-bit dword offset and the current PC. The result is registered and appears one cycle later, together with a one-cycle valid strobe.

Top module: `cmask_branch_unit`

## Requirements
- R1: While reset is held (active-low `rstN`), and right after it, `nextPc`, `nextPcBytes`, `taken`, `nextValid`, `condView` and `maskView` are all zero.
- R2: Each 32-bit half of the condition register and of the lane mask is written from `wrData` by its own strobe, on the clock edge where the strobe is high. Writing one half leaves the other half and the other register unchanged.
- R3: When `laneMode64` is 0, bits 63:32 of `condView` and `maskView` read as zero. The stored high halves are kept and reappear as soon as `laneMode64` is 1.
- R4: `brType` 2'b01 (branch-if-nonzero) is taken exactly when the mode-masked condition value is nonzero.
- R5: `brType` 2'b10 (branch-if-zero) is taken exactly when the mode-masked condition value is zero.
- R6: With the high half 0x80000000 and the low half 0 in 32-lane mode, branch-if-nonzero is not taken and branch-if-zero is taken. In 64-lane mode the same contents give the opposite results.
- R7: `nextPc` is `pcIn + 1 + signext(brOffset)` when taken and `pcIn + 1` otherwise, modulo 2^PC_W.
- R8: `nextPcBytes` always equals `nextPc` times 4.
- R9: A request presented with `brValid` high on one clock edge shows its results after that edge. `nextValid` is high for exactly that one cycle. Without a request, `nextPc` and `taken` hold their values and `nextValid` is low.
- R10: `brType` 2'b00 (sequential) and 2'b11 (reserved) are never taken.
- R11: A branch and a condition write on the same edge test the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneMode64 | input | 1 | 1: 64-lane operation, 0: 32-lane operation |
| wrData | input | 32 | Data for half-register writes |
| condWrLo | input | 1 | Write low half of condition register |
| condWrHi | input | 1 | Write high half of condition register |
| maskWrLo | input | 1 | Write low half of lane mask |
| maskWrHi | input | 1 | Write high half of lane mask |
| brValid | input | 1 | Branch request this cycle |
| brType | input | 2 | 00 sequential, 01 if-nonzero, 10 if-zero, 11 reserved |
| brOffset | input | 16 | Signed dword offset |
| pcIn | input | 30 | Current PC as dword index |
| nextPc | output | 30 | Registered next PC (dword index) |
| nextPcBytes | output | 32 | Byte form of nextPc |
| taken | output | 1 | Registered branch-taken flag |
| nextValid | output | 1 | One-cycle strobe for a new result |
| condView | output | 64 | Mode-masked condition register |
| maskView | output | 64 | Mode-masked lane mask |

## Verification
A half-register write takes one edge, so the bench reads `condView` and `maskView` at the falling edge after the write strobe. A mode change needs no edge at all. Branch results (`taken`, `nextPc`, `nextPcBytes`, `nextValid`) are due one edge after the `brValid` edge. They are sampled at the next falling edge and then checked again one cycle later, to confirm they hold and that the valid strobe has dropped. Inputs always change at falling edges, so every check sees a settled value.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

  typedef enum logic [1:0] {
    BR_SEQ = 2'b00,
    BR_NZ  = 2'b01,
    BR_Z   = 2'b10,
    BR_RSV = 2'b11
  } brKind_e;

  typedef struct packed {
    logic [1:0] condWe;   // [0] low half, [1] high half
    logic [1:0] maskWe;
    logic       evalEn;
    brKind_e    kind;
    logic       takeNow;
  } ctrlStrobes_t;

endpackage

// File: rtl/cmb_ctrl.sv
module cmb_ctrl
  import cmb_pkg::*;
(
  input  logic         condWrLo,
  input  logic         condWrHi,
  input  logic         maskWrLo,
  input  logic         maskWrHi,
  input  logic         brValid,
  input  logic [1:0]   brType,
  input  logic         condIsZero,
  output ctrlStrobes_t strobes
);

  brKind_e kind;
  logic    testHit;

  always_comb begin
    kind = brKind_e'(brType);
    unique case (kind)
      BR_NZ:   testHit = !condIsZero;
      BR_Z:    testHit = condIsZero;
      default: testHit = 1'b0;
    endcase
  end

  always_comb begin
    strobes.condWe  = {condWrHi, condWrLo};
    strobes.maskWe  = {maskWrHi, maskWrLo};
    strobes.evalEn  = brValid;
    strobes.kind    = kind;
    strobes.takeNow = brValid && testHit;
  end

endmodule

// File: rtl/cmb_datapath.sv
module cmb_datapath
  import cmb_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int PC_W   = 30,
  parameter int OFS_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                laneMode64,
  input  logic [HALF_W-1:0]   wrData,
  input  ctrlStrobes_t        strobes,
  input  logic [OFS_W-1:0]    brOffset,
  input  logic [PC_W-1:0]     pcIn,
  output logic                condIsZero,
  output logic [PC_W-1:0]     nextPc,
  output logic                taken,
  output logic                nextValid,
  output logic [2*HALF_W-1:0] condView,
  output logic [2*HALF_W-1:0] maskView
);

  localparam int FULL_W = 2 * HALF_W;
  localparam int EXT_W  = PC_W - OFS_W;

  logic [HALF_W-1:0] condHalf [2];
  logic [HALF_W-1:0] maskHalf [2];
  logic [HALF_W-1:0] hiGate;

  // Two independently written halves per register
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rstN) begin
        condHalf[h] <= '0;
        maskHalf[h] <= '0;
      end else begin
        if (strobes.condWe[h]) condHalf[h] <= wrData;
        if (strobes.maskWe[h]) maskHalf[h] <= wrData;
      end
    end
  end

  // High halves are hidden in 32-lane mode
  assign hiGate     = {HALF_W{laneMode64}};
  assign condView   = {condHalf[1] & hiGate, condHalf[0]};
  assign maskView   = {maskHalf[1] & hiGate, maskHalf[0]};
  assign condIsZero = (condView == '0);

  logic [PC_W-1:0] ofsExt;
  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] targetPc;

  assign ofsExt   = {{EXT_W{brOffset[OFS_W-1]}}, brOffset};
  assign seqPc    = pcIn + PC_W'(1);
  assign targetPc = strobes.takeNow ? (seqPc + ofsExt) : seqPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc    <= '0;
      taken     <= 1'b0;
      nextValid <= 1'b0;
    end else begin
      nextValid <= strobes.evalEn;
      if (strobes.evalEn) begin
        nextPc <= targetPc;
        taken  <= strobes.takeNow;
      end
    end
  end

  AST_NZ_TEST: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalEn && strobes.kind == BR_NZ) |=> (taken == ($past(condView) != '0))); // R4
  AST_Z_TEST: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalEn && strobes.kind == BR_Z) |=> (taken == ($past(condView) == '0))); // R5
  AST_STALE_HI: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalEn && strobes.kind == BR_NZ && !laneMode64 && condHalf[0] == '0) |=> !taken); // R6
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalEn && !strobes.takeNow) |=> (nextPc == PC_W'($past(pcIn) + PC_W'(1)))); // R7
  AST_RSV_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.evalEn && (strobes.kind == BR_SEQ || strobes.kind == BR_RSV)) |=> !taken); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.evalEn |=> (!nextValid && $stable(nextPc) && $stable(taken))); // R9
  AST_HALF_ISOLATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.condWe == 2'b01) |=> $stable(condHalf[1])); // R2

endmodule

// File: rtl/cmask_branch_unit.sv
module cmask_branch_unit
  import cmb_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int PC_W   = 30,
  parameter int OFS_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                laneMode64,
  input  logic [HALF_W-1:0]   wrData,
  input  logic                condWrLo,
  input  logic                condWrHi,
  input  logic                maskWrLo,
  input  logic                maskWrHi,
  input  logic                brValid,
  input  logic [1:0]          brType,
  input  logic [OFS_W-1:0]    brOffset,
  input  logic [PC_W-1:0]     pcIn,
  output logic [PC_W-1:0]     nextPc,
  output logic [PC_W+1:0]     nextPcBytes,
  output logic                taken,
  output logic                nextValid,
  output logic [2*HALF_W-1:0] condView,
  output logic [2*HALF_W-1:0] maskView
);

  ctrlStrobes_t strobes;
  logic         condIsZero;

  cmb_ctrl u_ctrl (
    .condWrLo  (condWrLo),
    .condWrHi  (condWrHi),
    .maskWrLo  (maskWrLo),
    .maskWrHi  (maskWrHi),
    .brValid   (brValid),
    .brType    (brType),
    .condIsZero(condIsZero),
    .strobes   (strobes)
  );

  cmb_datapath #(
    .HALF_W(HALF_W),
    .PC_W  (PC_W),
    .OFS_W (OFS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .laneMode64(laneMode64),
    .wrData    (wrData),
    .strobes   (strobes),
    .brOffset  (brOffset),
    .pcIn      (pcIn),
    .condIsZero(condIsZero),
    .nextPc    (nextPc),
    .taken     (taken),
    .nextValid (nextValid),
    .condView  (condView),
    .maskView  (maskView)
  );

  assign nextPcBytes = {nextPc, 2'b00};

endmodule

// File: tb/cmask_branch_unit_bench.sv
module cmask_branch_unit_bench;

  localparam int PC_W = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        laneMode64 = 1'b0;
  logic [31:0] wrData = '0;
  logic        condWrLo = 1'b0, condWrHi = 1'b0, maskWrLo = 1'b0, maskWrHi = 1'b0;
  logic        brValid = 1'b0;
  logic [1:0]  brType = '0;
  logic [15:0] brOffset = '0;
  logic [29:0] pcIn = '0;
  logic [29:0] nextPc;
  logic [31:0] nextPcBytes;
  logic        taken, nextValid;
  logic [63:0] condView, maskView;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  cmask_branch_unit u_cmask_branch_unit (
    .clk(clk), .rstN(rstN), .laneMode64(laneMode64), .wrData(wrData),
    .condWrLo(condWrLo), .condWrHi(condWrHi), .maskWrLo(maskWrLo), .maskWrHi(maskWrHi),
    .brValid(brValid), .brType(brType), .brOffset(brOffset), .pcIn(pcIn),
    .nextPc(nextPc), .nextPcBytes(nextPcBytes), .taken(taken), .nextValid(nextValid),
    .condView(condView), .maskView(maskView)
  );

  typedef struct packed {
    logic        m64;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [1:0]  kind;
    logic [15:0] ofs;
    logic [29:0] pc;
    logic        expTk;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,        32'h8000_0000, 2'b01, 16'd5,    30'd100,        1'b0}, // R6
    '{1'b0, 32'h0,        32'h8000_0000, 2'b10, 16'd5,    30'd100,        1'b1}, // R6
    '{1'b1, 32'h0,        32'h8000_0000, 2'b01, 16'hFFFD, 30'd100,        1'b1}, // R6
    '{1'b1, 32'h0,        32'h8000_0000, 2'b10, 16'd5,    30'd100,        1'b0}, // R6
    '{1'b0, 32'h1,        32'h0,         2'b01, 16'd2,    30'd10,         1'b1}, // R4
    '{1'b0, 32'h1,        32'h0,         2'b10, 16'd2,    30'd10,         1'b0}, // R5
    '{1'b1, 32'h0,        32'h0,         2'b10, 16'hFFFF, 30'd0,          1'b1}, // R5
    '{1'b1, 32'h0,        32'h0,         2'b01, 16'hFFFF, 30'd0,          1'b0}, // R4
    '{1'b0, 32'hFFFF_FFFF, 32'h0,        2'b00, 16'd9,    30'd55,         1'b0}, // R10
    '{1'b0, 32'hFFFF_FFFF, 32'h0,        2'b11, 16'd9,    30'd55,         1'b0}, // R10
    '{1'b0, 32'h0,        32'h1,         2'b10, 16'd0,    30'h3FFF_FFFF,  1'b1}, // R7 wrap
    '{1'b1, 32'h0,        32'h0,         2'b10, 16'h8000, 30'd40000,      1'b1}, // R7 min
    '{1'b1, 32'h0,        32'h0,         2'b10, 16'h7FFF, 30'd0,          1'b1}  // R7 max
  };

  function automatic logic [29:0] modelPc(logic [29:0] pc, logic [15:0] ofs, logic tk);
    longint s;
    s = longint'(pc) + 1;
    if (tk) s = s + longint'($signed(ofs));
    return s[29:0];
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeHalf(bit isMask, bit isHi, logic [31:0] d);
    wrData = d;
    condWrLo = !isMask && !isHi; condWrHi = !isMask && isHi;
    maskWrLo = isMask && !isHi;  maskWrHi = isMask && isHi;
    tick();
    {condWrLo, condWrHi, maskWrLo, maskWrHi} = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [29:0] expPc;
    logic [29:0] heldPc;
    repeat (3) tick();
    // R1 reset state
    check("R1", "nextPc", 64'(nextPc), 64'd0);
    check("R1", "taken/valid", {62'd0, taken, nextValid}, 64'd0);
    check("R1", "condView", condView, 64'd0);
    check("R1", "maskView", maskView, 64'd0);
    rstN = 1'b1;
    tick();
    check("R1", "nextPcBytes after release", 64'(nextPcBytes), 64'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      laneMode64 = VECS[i].m64;
      writeHalf(1'b0, 1'b0, VECS[i].lo);
      writeHalf(1'b0, 1'b1, VECS[i].hi);
      brValid = 1'b1; brType = VECS[i].kind; brOffset = VECS[i].ofs; pcIn = VECS[i].pc;
      tick();
      brValid = 1'b0;
      expPc = modelPc(VECS[i].pc, VECS[i].ofs, VECS[i].expTk);
      check("R4/R5/R6/R10", $sformatf("taken vec %0d", i), 64'(taken), 64'(VECS[i].expTk));
      check("R7", $sformatf("nextPc vec %0d", i), 64'(nextPc), 64'(expPc));
      check("R8", $sformatf("bytes vec %0d", i), 64'(nextPcBytes), 64'(expPc) * 4);
      check("R9", $sformatf("valid vec %0d", i), 64'(nextValid), 64'd1);
      heldPc = nextPc;
      pcIn = ~pcIn; brOffset = ~brOffset;
      tick();
      check("R9", $sformatf("idle hold vec %0d", i), {32'(nextPc), 31'd0, nextValid}, {32'(heldPc), 32'd0});
    end

    // R2 half isolation and R3 mode masking
    laneMode64 = 1'b1;
    writeHalf(1'b0, 1'b0, 32'h1111_2222);
    writeHalf(1'b0, 1'b1, 32'h3333_4444);
    writeHalf(1'b0, 1'b0, 32'h5555_6666);
    check("R2", "cond lo rewrite keeps hi", condView, 64'h3333_4444_5555_6666);
    writeHalf(1'b1, 1'b1, 32'hA5A5_A5A5);
    writeHalf(1'b1, 1'b0, 32'h0000_00FF);
    check("R2", "mask halves", maskView, 64'hA5A5_A5A5_0000_00FF);
    check("R2", "cond untouched by mask write", condView, 64'h3333_4444_5555_6666);
    laneMode64 = 1'b0;
    tick();
    check("R3", "cond 32-lane", condView, 64'h0000_0000_5555_6666);
    check("R3", "mask 32-lane", maskView, 64'h0000_0000_0000_00FF);
    laneMode64 = 1'b1;
    tick();
    check("R3", "hi restored", condView, 64'h3333_4444_5555_6666);

    // R11 write and branch on the same edge
    laneMode64 = 1'b0;
    writeHalf(1'b0, 1'b0, 32'h0);
    wrData = 32'h5; condWrLo = 1'b1;
    brValid = 1'b1; brType = 2'b10; brOffset = 16'd4; pcIn = 30'd20;
    tick();
    condWrLo = 1'b0; brValid = 1'b0;
    check("R11", "taken on old zero", 64'(taken), 64'd1);
    check("R11", "pc on old zero", 64'(nextPc), 64'd25);
    check("R2", "write landed", condView, 64'h5);
    brValid = 1'b1; brType = 2'b01; brOffset = 16'd1; pcIn = 30'd7;
    tick();
    brValid = 1'b0;
    check("R4", "nz after write", {62'd0, taken, nextValid}, 64'd3);
    check("R7", "nz target", 64'(nextPc), 64'd9);

    summary();
    $finish;
  end

endmodule